// File: doc/BRIEF.md
# Double-Buffered PWM Channel

This block is one 8-bit pulse-width modulation channel. Software programs a control register (enable, start level, alignment), a period value and a duty value, all through a small write/read register port. The counter advances once per pulse on `tick`, a clock-enable strobe from a prescaler outside the block. The channel drives a single waveform, either edge aligned (counter rises and wraps) or center aligned (counter rises to the period and falls back to zero).

Period and duty each have two copies: a buffer that software writes and an active copy that the comparators use. While the channel runs, the active copies change only at a cycle boundary, on a counter write or when the channel is switched off. Each cycle therefore uses either the old settings or the new ones and never a mix. While the channel is stopped, writes take effect at once. A write to the counter clears it and reloads both active values in the same clock. This lets software force a new setting in mid-cycle, at the cost of one shortened cycle.

Top module: `dbuf_pwm_chan`

## Requirements
- R1: After reset the control register reads 0 (disabled, start level low, edge aligned), the period buffer reads 0xFF, the duty buffer reads 0, the counter reads 0, and `pwm_out` is 1.
- R2: The counter changes only on a clock edge where `tick` is 1 and the enable bit is 1, or on a counter write. With no tick, or while disabled, it holds its value.
- R3: In edge-aligned mode (control bit 2 = 0) the counter runs 0, 1, …, P−1 and then returns to 0, so one cycle lasts P ticks, where P is the active period. The output is at its start level while counter < D (active duty) and at the opposite level otherwise.
- R4: Control bit 1 selects the start level: 1 means the output starts each cycle high, 0 means it starts low.
- R5: In center-aligned mode (control bit 2 = 1) the counter rises from 0 to P and then falls to 0, so one cycle lasts 2·P ticks. The same counter < D comparison applies on the way up and on the way down.
- R6: An active duty of 0 keeps an enabled output at the opposite level for the whole cycle. An active duty ≥ P keeps it at the start level for the whole cycle.
- R7: While enabled, a period or duty write changes only the buffer. The active copy takes the buffer value when the counter returns to 0 at the end of a cycle.
- R8: While disabled (control bit 0 = 0), a period or duty write updates the buffer and the active copy in the same clock.
- R9: A counter write (select 3) sets the counter to 0 and the count direction to up, and loads both buffered values into the active copies in the same clock.
- R10: Clearing the enable bit loads both buffered values into the active copies. While disabled, the counter holds and `pwm_out` equals the inverse of the start level.
- R11: The read port returns, for `rd_sel` 0/1/2/3: control bits {center, polarity, enable} in bits 2:0, period buffer, duty buffer, and the current counter value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Count strobe from the external prescaler |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 period, 2 duty, 3 counter |
| wr_data | input | 8 | Write data |
| rd_sel | input | 2 | Read target, same encoding as `wr_sel` |
| rd_data | output | 8 | Read data for `rd_sel` |
| pwm_out | output | 1 | PWM waveform |

## Verification
The bench builds the channel with its default 8-bit counter, and the reset period is the all-ones value. Short programmed periods (3 to 5) bring the wrap, the center-aligned turn-around and the zero-return reload within a handful of ticks. The same width still allows a duty of 9 to exceed a period of 5, which exercises the clamped full-duty case. Pending buffer changes are written in mid-cycle in both alignments and across disable and counter writes, so that each reload path is observed against a model of the requirements.

// File: rtl/dbuf_pwm_pkg.sv
`timescale 1ns/1ps
// Shared types for the double-buffered PWM channel.
// Assumes a two-bit register select and a three-bit control field.
package dbuf_pwm_pkg;

    // Register select encoding used by both the write and the read port
    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_PERIOD = 2'd1,
        SEL_DUTY   = 2'd2,
        SEL_COUNT  = 2'd3
    } pwm_sel_e;

    // Count direction used in center-aligned mode
    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } pwm_dir_e;

    // Control field layout
    localparam int CTL_EN_BIT  = 0;
    localparam int CTL_POL_BIT = 1;
    localparam int CTL_CTR_BIT = 2;
    localparam int CTL_W       = 3;

endpackage

// File: rtl/dbuf_pwm_ctrl.sv
`timescale 1ns/1ps
// Control register and write decode for the PWM channel.
// Holds enable, start level and alignment. Produces one-cycle strobes
// for period, duty and counter writes, and a pulse when the enable bit
// is cleared while the channel runs. Enable changes only on a clock edge.
module dbuf_pwm_ctrl
    import dbuf_pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CTL_W-1:0] ctl_data,
    output logic [CTL_W-1:0] ctrl_q,
    output logic             en_o,
    output logic             pol_o,
    output logic             center_o,
    output logic             per_wr_o,
    output logic             duty_wr_o,
    output logic             cnt_wr_o,
    output logic             dis_pulse_o
);

    logic ctrl_wr;

    // Decode the write strobes from the select
    always_comb begin
        ctrl_wr     = wr_en && (pwm_sel_e'(wr_sel) == SEL_CTRL);
        per_wr_o    = wr_en && (pwm_sel_e'(wr_sel) == SEL_PERIOD);
        duty_wr_o   = wr_en && (pwm_sel_e'(wr_sel) == SEL_DUTY);
        cnt_wr_o    = wr_en && (pwm_sel_e'(wr_sel) == SEL_COUNT);
        dis_pulse_o = ctrl_wr && ctrl_q[CTL_EN_BIT] && !ctl_data[CTL_EN_BIT];
    end

    // Control register update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q <= ctl_data;
        end
    end

    assign en_o     = ctrl_q[CTL_EN_BIT];
    assign pol_o    = ctrl_q[CTL_POL_BIT];
    assign center_o = ctrl_q[CTL_CTR_BIT];

    // R2
    en_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_o != $past(en_o)) |-> $past(wr_en && (pwm_sel_e'(wr_sel) == SEL_CTRL)));

endmodule

// File: rtl/dbuf_pwm_shadow.sv
`timescale 1ns/1ps
// One double-buffered setting (period or duty).
// Software writes the buffer. The active copy follows the buffer on a
// load request, or together with the buffer while the channel is
// disabled. A load in the same clock as a buffer write takes the
// previous buffer value.
module dbuf_pwm_shadow #(
    parameter int          W       = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         en,
    input  logic         load,
    output logic [W-1:0] buf_q,
    output logic [W-1:0] act_q
);

    // Buffer write and active-copy reload
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q <= RST_VAL;
            act_q <= RST_VAL;
        end else begin
            if (wr) begin
                buf_q <= wdata;
            end
            if (wr && !en) begin
                act_q <= wdata;
            end else if (load) begin
                act_q <= buf_q;
            end
        end
    end

    // R7
    act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !load) |=> $stable(act_q));

    // R9
    act_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && load) |=> (act_q == $past(buf_q)));

endmodule

// File: rtl/dbuf_pwm_counter.sv
`timescale 1ns/1ps
// Channel counter with edge-aligned and center-aligned sequencing.
// Edge aligned: 0..P-1 then wrap. Center aligned: 0 up to P, then down to 0.
// A cycle end (return to 0) raises reload_o. A counter write clears the
// counter, sets the direction to up and overrides any tick in that clock.
module dbuf_pwm_counter
    import dbuf_pwm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         en,
    input  logic         center,
    input  logic         cnt_wr,
    input  logic [W-1:0] per_act,
    output logic [W-1:0] cnt_q,
    output logic         reload_o
);

    localparam logic [W:0]   ONE_X = {{W{1'b0}}, 1'b1};
    localparam logic [W-1:0] ONE   = {{(W-1){1'b0}}, 1'b1};

    pwm_dir_e   dir_q, dir_n;
    logic [W-1:0] cnt_n;
    logic [W:0]   cnt_inc;
    logic         wrap;

    // Next count and direction for a tick
    always_comb begin
        cnt_n   = cnt_q;
        dir_n   = dir_q;
        wrap    = 1'b0;
        cnt_inc = {1'b0, cnt_q} + ONE_X;
        if (en && tick) begin
            if (!center) begin
                dir_n = DIR_UP;
                if (cnt_inc >= {1'b0, per_act}) begin
                    cnt_n = '0;
                    wrap  = 1'b1;
                end else begin
                    cnt_n = cnt_inc[W-1:0];
                end
            end else if ((dir_q == DIR_UP) && (cnt_q < per_act)) begin
                cnt_n = cnt_inc[W-1:0];
            end else if (cnt_q <= ONE) begin
                cnt_n = '0;
                dir_n = DIR_UP;
                wrap  = 1'b1;
            end else begin
                cnt_n = cnt_q - ONE;
                dir_n = DIR_DOWN;
            end
        end
    end

    // Counter and direction registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            dir_q <= DIR_UP;
        end else if (cnt_wr) begin
            cnt_q <= '0;
            dir_q <= DIR_UP;
        end else begin
            cnt_q <= cnt_n;
            dir_q <= dir_n;
        end
    end

    assign reload_o = wrap && !cnt_wr;

    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(en && tick) && !cnt_wr) |=> $stable(cnt_q));

    // R9
    cnt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt_q == '0));

endmodule

// File: rtl/dbuf_pwm_wave.sv
`timescale 1ns/1ps
// Output stage: compares the counter with the active duty.
// Start level while count < duty, or whenever duty >= period.
// Disabled output sits at the inverse of the start level.
// Inputs are all registered, so the output changes only after a clock edge.
module dbuf_pwm_wave #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         pol,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] duty_act,
    input  logic [W-1:0] per_act,
    output logic         pwm_o
);

    logic at_start;

    // Decide the waveform level from the comparators
    always_comb begin
        at_start = (duty_act >= per_act) || (cnt < duty_act);
        pwm_o    = (en && at_start) ? pol : !pol;
    end

    // R6
    zero_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (duty_act == '0) && (per_act != '0)) |-> (pwm_o == !pol));

    // R6
    full_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (duty_act >= per_act)) |-> (pwm_o == pol));

endmodule

// File: rtl/dbuf_pwm_chan.sv
`timescale 1ns/1ps
// Double-buffered PWM channel, top level.
// Joins the control register, two buffered settings, the counter and the
// output stage, and muxes the read port. Assumes tick is a single-clock
// strobe from an external prescaler and W >= CTL_W.
module dbuf_pwm_chan
    import dbuf_pwm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic [1:0]   rd_sel,
    output logic [W-1:0] rd_data,
    output logic         pwm_out
);

    localparam logic [W-1:0] PER_RST  = {W{1'b1}};
    localparam logic [W-1:0] DUTY_RST = '0;

    logic [CTL_W-1:0] ctrl_q;
    logic en, pol, center;
    logic per_wr, duty_wr, cnt_wr, dis_pulse;
    logic reload, load_all;
    logic [W-1:0] per_buf, per_act, duty_buf, duty_act, cnt;

    dbuf_pwm_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .ctl_data   (wr_data[CTL_W-1:0]),
        .ctrl_q     (ctrl_q),
        .en_o       (en),
        .pol_o      (pol),
        .center_o   (center),
        .per_wr_o   (per_wr),
        .duty_wr_o  (duty_wr),
        .cnt_wr_o   (cnt_wr),
        .dis_pulse_o(dis_pulse)
    );

    // Any of the three reload conditions moves both buffers at once
    assign load_all = reload || cnt_wr || dis_pulse;

    dbuf_pwm_shadow #(.W(W), .RST_VAL(PER_RST)) u_period (
        .clk  (clk),
        .rst_n(rst_n),
        .wr   (per_wr),
        .wdata(wr_data),
        .en   (en),
        .load (load_all),
        .buf_q(per_buf),
        .act_q(per_act)
    );

    dbuf_pwm_shadow #(.W(W), .RST_VAL(DUTY_RST)) u_duty (
        .clk  (clk),
        .rst_n(rst_n),
        .wr   (duty_wr),
        .wdata(wr_data),
        .en   (en),
        .load (load_all),
        .buf_q(duty_buf),
        .act_q(duty_act)
    );

    dbuf_pwm_counter #(.W(W)) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .en      (en),
        .center  (center),
        .cnt_wr  (cnt_wr),
        .per_act (per_act),
        .cnt_q   (cnt),
        .reload_o(reload)
    );

    dbuf_pwm_wave #(.W(W)) u_wave (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .pol     (pol),
        .cnt     (cnt),
        .duty_act(duty_act),
        .per_act (per_act),
        .pwm_o   (pwm_out)
    );

    // Read-port multiplexer
    always_comb begin
        case (pwm_sel_e'(rd_sel))
            SEL_CTRL:   rd_data = {{(W-CTL_W){1'b0}}, ctrl_q};
            SEL_PERIOD: rd_data = per_buf;
            SEL_DUTY:   rd_data = duty_buf;
            default:    rd_data = cnt;
        endcase
    end

    // R10
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dis_pulse |=> (pwm_out == !pol));

endmodule

// File: tb/dbuf_pwm_chan_tb.sv
`timescale 1ns/1ps
module dbuf_pwm_chan_tb_top;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [W-1:0] wr_data = '0;
    logic [1:0] rd_sel = 2'd3;
    logic [W-1:0] rd_data;
    logic pwm_out;

    always #2.5 clk = ~clk;

    dbuf_pwm_chan #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .pwm_out(pwm_out)
    );

    typedef struct {
        string        req;
        logic [W-1:0] cnt;
        logic         out;
    } exp_t;

    exp_t exp_q[$];
    exp_t mon_e;
    int total = 0;
    int bad = 0;

    // Requirement model state
    logic m_en = 1'b0, m_pol = 1'b0, m_ctr = 1'b0, m_up = 1'b1;
    logic [W-1:0] m_cnt = '0, m_pb = '1, m_pa = '1, m_db = '0, m_da = '0;

    function automatic logic m_out();
        if (!m_en) return !m_pol;
        return ((m_da >= m_pa) || (m_cnt < m_da)) ? m_pol : !m_pol;
    endfunction

    function automatic void m_reload();
        m_pa = m_pb;
        m_da = m_db;
    endfunction

    // One tick of the counter as R3 and R5 describe it
    function automatic void m_advance();
        if (!m_en) return;
        if (!m_ctr) begin
            m_up = 1'b1;
            if ({1'b0, m_cnt} + 9'd1 >= {1'b0, m_pa}) begin m_cnt = '0; m_reload(); end
            else m_cnt = m_cnt + 1'b1;
        end else if (m_up && (m_cnt < m_pa)) begin
            m_cnt = m_cnt + 1'b1;
        end else if (m_cnt <= 1) begin
            m_cnt = '0; m_up = 1'b1; m_reload();
        end else begin
            m_cnt = m_cnt - 1'b1; m_up = 1'b0;
        end
    endfunction

    task automatic push(input string r);
        exp_t e;
        e.req = r; e.cnt = m_cnt; e.out = m_out();
        exp_q.push_back(e);
    endtask

    // Monitor: pops one expected item per cycle, away from the active edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            mon_e = exp_q.pop_front();
            total++;
            if (rd_data !== mon_e.cnt || pwm_out !== mon_e.out) begin
                bad++;
                $display("FAIL %s: cnt=%0d out=%0b expected cnt=%0d out=%0b",
                         mon_e.req, rd_data, pwm_out, mon_e.cnt, mon_e.out);
            end
        end
    end

    // Driver tasks: all start and end just after a rising edge
    task automatic do_tick(input string r, input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(posedge clk); #1;
            tick = 1'b0;
            m_advance();
            push(r);
        end
    endtask

    task automatic idle(input string r, input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            push(r);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [W-1:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
        case (sel)
            2'd0: begin
                if (m_en && !d[0]) m_reload();
                m_en = d[0]; m_pol = d[1]; m_ctr = d[2];
            end
            2'd1: begin m_pb = d; if (!m_en) m_pa = d; end
            2'd2: begin m_db = d; if (!m_en) m_da = d; end
            default: begin m_cnt = '0; m_up = 1'b1; m_reload(); end
        endcase
    endtask

    task automatic rd_chk(input logic [1:0] sel, input logic [W-1:0] e, input string r);
        rd_sel = sel;
        #0.5;
        total++;
        if (rd_data !== e) begin
            bad++;
            $display("FAIL %s: rd_sel=%0d read=%0h expected=%0h", r, sel, rd_data, e);
        end
        rd_sel = 2'd3;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state
        idle("R1", 1);
        rd_chk(2'd0, 8'h00, "R1");
        rd_chk(2'd1, 8'hFF, "R1");
        rd_chk(2'd2, 8'h00, "R1");
        // R8: writes while disabled go straight to the active copy; R11 readback
        wr(2'd1, 8'd5);
        wr(2'd2, 8'd2);
        rd_chk(2'd1, 8'd5, "R11");
        rd_chk(2'd2, 8'd2, "R11");
        wr(2'd0, 8'b011);
        rd_chk(2'd0, 8'b011, "R11");
        idle("R8", 1);
        // R3: edge aligned, period 5, duty 2, start high
        do_tick("R3", 12);
        // R2: no tick, counter holds
        idle("R2", 3);
        // R4: start level low
        wr(2'd0, 8'b001);
        do_tick("R4", 6);
        // R7: pending duty change in mid-cycle
        do_tick("R7", 1);
        wr(2'd2, 8'd4);
        rd_chk(2'd2, 8'd4, "R11");
        do_tick("R7", 8);
        // R6: zero duty, then duty above period
        wr(2'd2, 8'd0);
        do_tick("R6", 10);
        wr(2'd2, 8'd9);
        do_tick("R6", 10);
        // R9: counter write reloads a pending period in mid-cycle
        wr(2'd1, 8'd3);
        do_tick("R9", 1);
        wr(2'd3, 8'd0);
        idle("R9", 1);
        do_tick("R9", 6);
        // R10: disable loads the pending duty; disabled counter holds
        do_tick("R10", 1);
        wr(2'd2, 8'd1);
        wr(2'd0, 8'b000);
        idle("R10", 1);
        do_tick("R2", 3);
        wr(2'd0, 8'b001);
        do_tick("R10", 4);
        // R5: center aligned, period 4, duty 2, start high
        wr(2'd1, 8'd4);
        wr(2'd2, 8'd2);
        wr(2'd0, 8'b111);
        wr(2'd3, 8'd0);
        do_tick("R5", 20);
        // R7: pending duty in center mode waits for return to zero
        do_tick("R7", 2);
        wr(2'd2, 8'd3);
        do_tick("R7", 12);
        idle("R5", 2);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule